// File: doc/BRIEF.md
# Retention-Aware Buffer Refresh Controller

This block watches the entries of per-virtual-channel flit buffers built from storage cells that hold data only for a limited number of cycles. Each VC buffer is modelled as a circular queue of `DEPTH` slots. The controller follows write and read events for every VC and keeps an age counter for every occupied slot. When stored data gets close to its retention limit, it asks an external datapath to read the slot and write it back. When data outlives the limit anyway, it reports the slot as dropped.

Two policies are available, chosen by one mode input.

- **Head policy.** Only the oldest flit of each VC is checked. It is refreshed once its remaining lifetime falls below a threshold.
- **Lazy policy.** The controller counts the flits of a VC that are close to expiry. When their share of the occupied slots exceeds a selectable fraction, it schedules a rewrite of every live flit in that VC.

Each rewrite occupies the VC's storage bank for two cycles. Buffer traffic on a VC always wins over refresh.

Top module: `rr_refresh_ctrl`

## Requirements
- R1: After reset all queues are empty, and `rf_req_o` and `drop_o` are all zero.
- R2: A write on a VC fills the next slot in circular order, starting at slot 0 after reset, and a read frees the oldest slot. A write while `DEPTH` slots are held is ignored.
- R3: A slot's age starts at 0 in the cycle after its write. The age grows by one per cycle and saturates at `RET_CYCLES`. The slot's bit of `drop_o` (index vc*DEPTH+slot) is high for exactly one cycle, the one in which its age equals `RET_CYCLES-1`. This does not happen if the slot is read in that cycle or finishes a rewrite in that cycle.
- R4: With `mode_i`=0 and no lazy work pending, a VC requests its head slot when `RET_CYCLES - age < thresh_i`. Other slots of that VC are never requested this way.
- R5: A request in cycle t keeps that VC from requesting in cycle t+1. The requested slot shows age 0 in cycle t+2, unless it is read in cycle t+1.
- R6: A VC does not request in any cycle in which its write or read input is high.
- R7: With `mode_i`=1, let near = live slots with `RET_CYCLES - age < thresh_i`, and occ = the occupied-slot count. The VC triggers when near*4 > q*occ, where `ratio_i` codes 0/1/2/3 give q = 1/2/3/4. That is 25%, 50% or 75%, and code 3 never triggers. Triggering needs no lazy work pending and no rewrite in progress.
- R8: A trigger marks every live slot, and the marked slots are requested lowest slot index first. A mark is removed when its slot is requested, read or expires.
- R9: A slot whose age has reached `RET_CYCLES` is never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | NUM_VC | Per-VC flit write event |
| rd_i | input | NUM_VC | Per-VC flit read (head removal) event |
| mode_i | input | 1 | 0 head policy, 1 lazy policy |
| thresh_i | input | AGE_W | Remaining-lifetime threshold |
| ratio_i | input | 2 | Lazy trigger fraction code |
| rf_req_o | output | NUM_VC | Per-VC rewrite request |
| rf_idx_o | output | NUM_VC*IDX_W | Slot index of each VC's request |
| drop_o | output | NUM_VC*DEPTH | Per-slot expiry pulse |

## Verification
The hardest situation to reach is a lazy trigger whose near-expiry share sits just above or just below the selected fraction. A drain that is then interleaved with reads and with flits crossing the limit adds to the difficulty. The stimulus gets there by staging flits with staggered write times separated by long idle gaps, so that a chosen number of slots enters the near-expiry window together. A long randomized phase with sparse reads and rotating mode and ratio settings then mixes rewrites, expiries and traffic. A behavioural model in the bench tracks every slot and checks the outputs in every cycle.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic {
        RR_HEAD = 1'b0,
        RR_LAZY = 1'b1
    } rr_mode_e;

    // Trigger fraction expressed in quarters of the occupancy.
    function automatic logic [2:0] rr_quarters(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/rr_lsb_pick.sv
module rr_lsb_pick #(
    parameter int W     = 4,
    parameter int IDX_W = 2
) (
    input  logic [W-1:0]     mask_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IDX_W'(i);
        end
        found_o = |mask_i;
    end
endmodule

// File: rtl/rr_ratio_cmp.sv
module rr_ratio_cmp #(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] near_i,
    input  logic [CNT_W-1:0] occ_i,
    input  logic [1:0]       code_i,
    output logic             over_o
);
    import rr_pkg::*;
    localparam int L = CNT_W + 3;
    logic [L-1:0] lhs, rhs;
    always_comb begin
        lhs    = L'(near_i) << 2;
        rhs    = L'(occ_i) * L'(rr_quarters(code_i));
        over_o = lhs > rhs;
    end
endmodule

// File: rtl/rr_vc_ctrl.sv
module rr_vc_ctrl #(
    parameter int DEPTH = 4,
    parameter int RET   = 200,
    parameter int AGE_W = 8,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic             mode_i,
    input  logic [AGE_W-1:0] thresh_i,
    input  logic [1:0]       ratio_i,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [DEPTH-1:0] drop_o
);
    import rr_pkg::*;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RET);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);

    typedef struct {
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] pend;
        logic [AGE_W-1:0] age [DEPTH];
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic [IDX_W-1:0] bidx;
    } vc_st_t;

    vc_st_t st_d, st_q;

    logic [DEPTH-1:0] pop_m, wr_m, done_m, live_m, near_m, cand_m;
    logic [CNT_W-1:0] near_cnt;
    logic             wr_ok, pop_ok, quiet, head_hot, fire, over;
    logic             pk_found;
    logic [IDX_W-1:0] pk_idx;

    rr_lsb_pick #(.W(DEPTH), .IDX_W(IDX_W)) u_pick (
        .mask_i(cand_m), .found_o(pk_found), .idx_o(pk_idx)
    );

    rr_ratio_cmp #(.CNT_W(CNT_W)) u_ratio (
        .near_i(near_cnt), .occ_i(st_q.cnt), .code_i(ratio_i), .over_o(over)
    );

    always_comb begin
        st_d     = st_q;
        wr_ok    = wr_i && (st_q.cnt < CNT_W'(DEPTH));
        pop_ok   = rd_i && (st_q.cnt != '0);
        near_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            live_m[i] = st_q.vld[i] && (st_q.age[i] != AGE_MAX);
            near_m[i] = live_m[i] && ((AGE_MAX - st_q.age[i]) < thresh_i);
            pop_m[i]  = pop_ok && (st_q.head == IDX_W'(i));
            wr_m[i]   = wr_ok && (st_q.tail == IDX_W'(i));
            done_m[i] = st_q.busy && (st_q.bidx == IDX_W'(i)) && st_q.vld[i] && !pop_m[i];
            drop_o[i] = st_q.vld[i] && !pop_m[i] && !done_m[i]
                        && (st_q.age[i] == AGE_MAX - 1'b1);
            near_cnt  = near_cnt + CNT_W'(near_m[i]);
        end
        cand_m   = st_q.pend & live_m;
        quiet    = !wr_i && !rd_i && !st_q.busy;
        head_hot = (rr_mode_e'(mode_i) == RR_HEAD) && (st_q.pend == '0) && near_m[st_q.head];
        req_o    = quiet && (pk_found || head_hot);
        idx_o    = pk_found ? pk_idx : st_q.head;
        fire     = (rr_mode_e'(mode_i) == RR_LAZY) && (st_q.pend == '0) && !st_q.busy
                   && (st_q.cnt != '0) && over;

        for (int i = 0; i < DEPTH; i++) begin
            st_d.vld[i] = (st_q.vld[i] && !pop_m[i]) || wr_m[i];
            if (wr_m[i] || done_m[i])
                st_d.age[i] = '0;
            else if (st_q.vld[i] && !pop_m[i])
                st_d.age[i] = (st_q.age[i] == AGE_MAX) ? AGE_MAX : st_q.age[i] + 1'b1;
            else
                st_d.age[i] = '0;
            if (fire)
                st_d.pend[i] = st_q.vld[i] && !pop_m[i] && live_m[i];
            else
                st_d.pend[i] = st_q.pend[i] && !pop_m[i] && live_m[i]
                               && !(req_o && idx_o == IDX_W'(i));
        end
        st_d.busy = req_o;
        st_d.bidx = idx_o;
        if (pop_ok) st_d.head = (st_q.head == LAST) ? '0 : st_q.head + 1'b1;
        if (wr_ok)  st_d.tail = (st_q.tail == LAST) ? '0 : st_q.tail + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(wr_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{default: '0};
        else         st_q <= st_d;
    end

    // R2
    occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_W'(DEPTH));
    // R5
    back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |=> !req_o);
    // R5
    rewrite_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy && !pop_m[st_q.bidx] |=> st_q.age[$past(st_q.bidx)] == '0);
    // R6
    traffic_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i || rd_i) |-> !req_o);
    // R9
    no_stale_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> st_q.age[idx_o] != AGE_MAX);
    // R7
    ratio_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire |-> ratio_i != 2'd3);

    for (genvar g = 0; g < DEPTH; g++) begin : g_drop_chk
        // R3
        drop_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            drop_o[g] |=> st_q.age[g] == AGE_MAX);
    end
endmodule

// File: rtl/rr_refresh_ctrl.sv
module rr_refresh_ctrl #(
    parameter int NUM_VC     = 2,
    parameter int DEPTH      = 4,
    parameter int RET_CYCLES = 200,
    parameter int AGE_W      = $clog2(RET_CYCLES + 1),
    parameter int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_VC-1:0]         wr_i,
    input  logic [NUM_VC-1:0]         rd_i,
    input  logic                      mode_i,
    input  logic [AGE_W-1:0]          thresh_i,
    input  logic [1:0]                ratio_i,
    output logic [NUM_VC-1:0]         rf_req_o,
    output logic [NUM_VC*IDX_W-1:0]   rf_idx_o,
    output logic [NUM_VC*DEPTH-1:0]   drop_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        rr_vc_ctrl #(
            .DEPTH(DEPTH), .RET(RET_CYCLES), .AGE_W(AGE_W),
            .IDX_W(IDX_W), .CNT_W(CNT_W)
        ) u_vc (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_i[v]),
            .rd_i    (rd_i[v]),
            .mode_i  (mode_i),
            .thresh_i(thresh_i),
            .ratio_i (ratio_i),
            .req_o   (rf_req_o[v]),
            .idx_o   (rf_idx_o[v*IDX_W +: IDX_W]),
            .drop_o  (drop_o[v*DEPTH +: DEPTH])
        );
    end
endmodule

// File: tb/tb_rr_refresh_ctrl.sv
module tb_rr_refresh_ctrl;
    localparam int NV = 2, D = 4, RET = 200, AW = 8, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NV-1:0] wr_i = '0, rd_i = '0;
    logic mode_i = 1'b0;
    logic [AW-1:0] thresh_i = '0;
    logic [1:0] ratio_i = '0;
    logic [NV-1:0] rf_req_o;
    logic [NV*IW-1:0] rf_idx_o;
    logic [NV*D-1:0] drop_o;

    int n_chk = 0, n_fail = 0;
    int obs_req = 0, obs_drop = 0, obs_badidx = 0;
    bit done = 0;

    int m_vld[NV][D], m_age[NV][D], m_pend[NV][D];
    int m_head[NV], m_tail[NV], m_cnt[NV], m_busy[NV], m_bidx[NV];

    always #4 clk = ~clk;

    rr_refresh_ctrl #(.NUM_VC(NV), .DEPTH(D), .RET_CYCLES(RET)) dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_i), .rd_i(rd_i), .mode_i(mode_i),
        .thresh_i(thresh_i), .ratio_i(ratio_i),
        .rf_req_o(rf_req_o), .rf_idx_o(rf_idx_o), .drop_o(drop_o)
    );

    task automatic chk(input bit ok, input string msg, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0d exp %0d", msg, got, exp);
        end
    endtask

    task automatic step(input logic [NV-1:0] wr, input logic [NV-1:0] rd, input string tag);
        int wa, po, nearc, ci, er, ei, fire, pany, hd, isp, isw, isd, gi;
        int live[D], near[D];
        @(negedge clk);
        wr_i = wr; rd_i = rd;
        #1;
        for (int v = 0; v < NV; v++) begin
            wa = (wr[v] && m_cnt[v] < D) ? 1 : 0;
            po = (rd[v] && m_cnt[v] > 0) ? 1 : 0;
            hd = m_head[v];
            nearc = 0; ci = -1; pany = 0;
            for (int s = 0; s < D; s++) begin
                live[s] = (m_vld[v][s] && m_age[v][s] != RET) ? 1 : 0;
                near[s] = (live[s] && (RET - m_age[v][s]) < int'(thresh_i)) ? 1 : 0;
                nearc += near[s];
                if (m_pend[v][s]) pany = 1;
                if (m_pend[v][s] && live[s] && ci < 0) ci = s;
            end
            er = 0; ei = 0;
            if (!wr[v] && !rd[v] && !m_busy[v]) begin
                if (ci >= 0) begin er = 1; ei = ci; end
                else if (mode_i == 1'b0 && !pany && near[hd]) begin er = 1; ei = hd; end
            end
            fire = (mode_i == 1'b1 && !pany && !m_busy[v] && m_cnt[v] > 0
                    && nearc * 4 > (int'(ratio_i) + 1) * m_cnt[v]) ? 1 : 0;
            // outputs
            chk(rf_req_o[v] == er[0], $sformatf("%s rf_req vc%0d", tag, v), rf_req_o[v], er);
            if (er) begin
                gi = int'(rf_idx_o[v*IW +: IW]);
                chk(gi == ei, $sformatf("%s rf_idx vc%0d", tag, v), gi, ei);
            end
            if (rf_req_o[v]) obs_req++;
            if (rf_req_o[v] && rf_idx_o[v*IW +: IW] != '0) obs_badidx++;
            for (int s = 0; s < D; s++) begin
                isp = (po && hd == s) ? 1 : 0;
                isd = (m_busy[v] && m_bidx[v] == s && m_vld[v][s] && !isp) ? 1 : 0;
                isw = (wa && m_tail[v] == s) ? 1 : 0;
                chk(drop_o[v*D+s] == (m_vld[v][s] && !isp && !isd && m_age[v][s] == RET-1),
                    $sformatf("R3 %s drop vc%0d slot%0d", tag, v, s), drop_o[v*D+s],
                    (m_vld[v][s] && !isp && !isd && m_age[v][s] == RET-1) ? 1 : 0);
                if (drop_o[v*D+s]) obs_drop++;
                // model update for this slot
                if (fire) m_pend[v][s] = (m_vld[v][s] && !isp && live[s]) ? 1 : 0;
                else m_pend[v][s] = (m_pend[v][s] && !isp && live[s] && !(er && ei == s)) ? 1 : 0;
                if (isw || isd) m_age[v][s] = 0;
                else if (m_vld[v][s] && !isp) m_age[v][s] = (m_age[v][s] >= RET) ? RET : m_age[v][s] + 1;
                else m_age[v][s] = 0;
                m_vld[v][s] = ((m_vld[v][s] && !isp) || isw) ? 1 : 0;
            end
            m_busy[v] = er; m_bidx[v] = ei;
            if (po) m_head[v] = (m_head[v] + 1) % D;
            if (wa) m_tail[v] = (m_tail[v] + 1) % D;
            m_cnt[v] = m_cnt[v] + wa - po;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step('0, '0, tag);
    endtask

    task automatic zero_obs();
        obs_req = 0; obs_drop = 0; obs_badidx = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            m_head[v] = 0; m_tail[v] = 0; m_cnt[v] = 0; m_busy[v] = 0; m_bidx[v] = 0;
            for (int s = 0; s < D; s++) begin
                m_vld[v][s] = 0; m_age[v][s] = 0; m_pend[v][s] = 0;
            end
        end
        repeat (3) @(negedge clk);
        #1;
        chk(rf_req_o == '0, "R1 reset rf_req", int'(rf_req_o), 0);
        chk(drop_o == '0, "R1 reset drop", int'(drop_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1");

        // Head policy: only slot 0 is kept alive, the other two expire.
        mode_i = 1'b0; thresh_i = 8'd10;
        zero_obs();
        step(2'b01, '0, "R2"); step(2'b01, '0, "R2"); step(2'b01, '0, "R2");
        idle(450, "R4");
        chk(obs_req > 1, "R4 head refreshed repeatedly", obs_req, 2);
        chk(obs_badidx == 0, "R4 only head slot requested", obs_badidx, 0);
        chk(obs_drop == 2, "R3 non-head flits expire once each", obs_drop, 2);
        step('0, 2'b01, "R2"); step('0, 2'b01, "R2"); step('0, 2'b01, "R2");

        // Threshold 0: nothing is refreshed and a lone flit drops once.
        thresh_i = 8'd0;
        zero_obs();
        step(2'b10, '0, "R3");
        idle(260, "R9");
        chk(obs_drop == 1, "R3 single drop pulse", obs_drop, 1);
        chk(obs_req == 0, "R9 expired flit never requested", obs_req, 0);
        step('0, 2'b10, "R2");

        // Traffic wins over refresh; overfill is ignored.
        thresh_i = 8'd10;
        zero_obs();
        step(2'b01, '0, "R6");
        idle(189, "R6");
        for (int k = 0; k < 5; k++) step(2'b01, '0, "R6");
        chk(obs_req == 0, "R6 no request during writes", obs_req, 0);
        idle(4, "R5");
        chk(obs_req == 1, "R5 one request after traffic", obs_req, 1);
        for (int k = 0; k < 5; k++) step('0, 2'b01, "R2");

        // Lazy policy, 50%: three old flits and one young flit.
        mode_i = 1'b1; ratio_i = 2'd1; thresh_i = 8'd20;
        zero_obs();
        step(2'b01, '0, "R7"); step(2'b01, '0, "R7"); step(2'b01, '0, "R7");
        idle(60, "R7");
        step(2'b01, '0, "R7");
        idle(150, "R8");
        chk(obs_req == 4, "R8 whole VC rewritten", obs_req, 4);
        chk(obs_drop == 0, "R8 no loss after lazy refresh", obs_drop, 0);
        for (int k = 0; k < 4; k++) step('0, 2'b01, "R2");

        // Ratio code 3 never triggers.
        ratio_i = 2'd3;
        zero_obs();
        for (int k = 0; k < 4; k++) step(2'b10, '0, "R7");
        idle(250, "R7");
        chk(obs_req == 0, "R7 ratio off gives no request", obs_req, 0);
        chk(obs_drop == 4, "R7 all flits expire with ratio off", obs_drop, 4);
        for (int k = 0; k < 4; k++) step('0, 2'b10, "R2");

        // Mixed random traffic.
        thresh_i = 8'd25;
        for (int k = 0; k < 3000; k++) begin
            logic [NV-1:0] w, r;
            mode_i  = ((k / 500) % 2) == 1;
            ratio_i = 2'((k / 1000) % 4);
            for (int v = 0; v < NV; v++) begin
                w[v] = ($urandom % 8) == 0;
                r[v] = ($urandom % 20) == 0;
            end
            step(w, r, "R8");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule